// File: doc/BRIEF.md
# Return Address Stack

A small circular stack in the instruction-fetch front end that predicts where subroutine returns will go. When the front end fetches a call, it presents the call's own fetch address. The block stores that address plus the 4-byte instruction size, which is where execution resumes after the call. When the front end fetches a return, the entry on top is removed. The entry that was on top before the pop is the predicted return target. A return therefore predicts correctly no matter how many call sites share the subroutine, which a target buffer indexed by the branch address cannot do.

The predicted target is driven combinationally from the current top slot, so fetch can use it in the same cycle it asks. The stack has a fixed number of slots. A parameter selects what happens on a push to a full stack. In wrap mode the oldest entry is overwritten. In freeze mode the push is dropped and the stack is left unchanged. The top pointer and the occupancy count are always visible as a checkpoint. A front end that squashes a mispredicted path can load a saved checkpoint back in one cycle. A restore does not rebuild slot contents.

Push, pop and restore are single-cycle strobes that the stack always accepts, so there is no valid/ready pairing and no back-pressure. Any combination of strobes is legal in any cycle, and each has the defined effect listed below. Detecting calls and returns and checking the prediction are done elsewhere.

Top module: `ras_top`

## Requirements
- R1: After reset the count is 0, the top pointer is 0, `pred_valid_o` and `full_o` are 0, `empty_o` is 1, and every slot holds 0, so `pred_target_o` is 0.
- R2: An accepted push writes `call_pc_i + 4` into the new top slot. From the clock edge that takes the push, `pred_target_o` shows that value and `pred_valid_o` is 1.
- R3: A pop on a non-empty stack lowers the count by one and moves the top back one slot, so nested calls come back in last-in, first-out order. `pred_valid_o` is 1 exactly when the count is non-zero.
- R4: A pop on an empty stack, with no push and no restore, leaves the count, the top pointer and `pred_target_o` unchanged, and `pred_valid_o` stays 0.
- R5: A push and a pop in the same cycle on a non-empty stack overwrite the top slot with the new address and leave the count and the pointer unchanged. On an empty stack the pair acts as a push alone.
- R6: In wrap mode (`OVF = OVF_WRAP`), a push alone to a full stack advances the pointer onto the oldest slot, overwrites it, and keeps the count at DEPTH. The next DEPTH pops return the newest DEPTH addresses, newest first.
- R7: In freeze mode (`OVF = OVF_FREEZE`), a push alone to a full stack is ignored: the count, the pointer and `pred_target_o` stay the same.
- R8: `ckpt_top_o` and `ckpt_cnt_o` show the current top pointer and count. A restore loads them from `restore_top_i` and `restore_cnt_i` at the next edge, with counts above DEPTH clamped to DEPTH. A restore takes priority over push and pop in the same cycle and leaves slot contents unchanged.
- R9: `full_o` is 1 exactly when the count equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Call fetched: push the return address |
| pop_i | input | 1 | Return fetched: pop the top entry |
| call_pc_i | input | AW (32) | Fetch address of the call |
| restore_i | input | 1 | Reload top pointer and count from the restore inputs |
| restore_top_i | input | PW (2) | Saved top pointer, must be below DEPTH |
| restore_cnt_i | input | CW (3) | Saved count |
| pred_target_o | output | AW (32) | Predicted return target, the current top slot |
| pred_valid_o | output | 1 | Stack holds at least one entry |
| empty_o | output | 1 | Count is zero |
| full_o | output | 1 | Count equals DEPTH |
| ckpt_top_o | output | PW (2) | Current top pointer, for checkpointing |
| ckpt_cnt_o | output | CW (3) | Current count, for checkpointing |

## Verification
The hardest case to reach from the ports is a restore after the speculative path has already written over a slot below the saved top. The repaired pointer must then expose the one overwritten entry and leave the others intact. The stimulus gets there by pushing two entries and recording the checkpoint outputs. It then pops both and pushes a new address into the slot the first entry used, and loads the checkpoint back, at first alone and later together with a push and a pop. One wrap-mode instance and one freeze-mode instance receive the same overflow sequence, so the two policies can be told apart on the first pop after the overflow. A long random phase, which also restores checkpoints saved at random times, is compared every cycle against a behavioural model.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // What a push to a full stack does
  typedef enum logic {
    OVF_WRAP   = 1'b0,  // overwrite the oldest entry
    OVF_FREEZE = 1'b1   // drop the push
  } ras_ovf_e;

  // Action taken at the next clock edge
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PUSH    = 3'd1,
    OP_POP     = 3'd2,
    OP_REPLACE = 3'd3,
    OP_RESTORE = 3'd4
  } ras_op_e;

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int       DEPTH = 4,
  parameter ras_ovf_e OVF   = OVF_WRAP,
  localparam int      PW    = $clog2(DEPTH),
  localparam int      CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          restore_i,
  input  logic [PW-1:0] restore_top_i,
  input  logic [CW-1:0] restore_cnt_i,
  output logic [PW-1:0] top_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_idx_o
);

  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [PW-1:0] top_q, up_idx, dn_idx;
  logic [CW-1:0] cnt_q, rst_cnt;
  logic          is_empty, is_full;
  ras_op_e       op;

  // circular neighbours of the top slot
  assign up_idx   = (top_q == LAST_IDX) ? '0 : top_q + PW'(1);
  assign dn_idx   = (top_q == '0) ? LAST_IDX : top_q - PW'(1);
  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == FULL_CNT);
  assign rst_cnt  = (restore_cnt_i > FULL_CNT) ? FULL_CNT : restore_cnt_i;

  // priority: restore, then push+pop replace, then push, then pop
  always_comb begin
    op = OP_IDLE;
    if (restore_i) begin
      op = OP_RESTORE;
    end else if (push_i && pop_i && !is_empty) begin
      op = OP_REPLACE;
    end else if (push_i) begin
      if (OVF == OVF_WRAP || !is_full) op = OP_PUSH;
    end else if (pop_i && !is_empty) begin
      op = OP_POP;
    end
  end

  always_comb begin
    wr_en_o  = (op == OP_PUSH) || (op == OP_REPLACE);
    wr_idx_o = (op == OP_REPLACE) ? top_q : up_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      cnt_q <= '0;
    end else begin
      case (op)
        OP_RESTORE: begin
          top_q <= restore_top_i;
          cnt_q <= rst_cnt;
        end
        OP_PUSH: begin
          top_q <= up_idx;
          if (!is_full) cnt_q <= cnt_q + CW'(1);
        end
        OP_POP: begin
          top_q <= dn_idx;
          cnt_q <= cnt_q - CW'(1);
        end
        default: ;
      endcase
    end
  end

  assign top_o   = top_q;
  assign cnt_o   = cnt_q;
  assign empty_o = is_empty;
  assign full_o  = is_full;

  // R4: popping an empty stack changes nothing
  a_r4_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && pop_i && !push_i && !restore_i) |=> (cnt_q == '0) && $stable(top_q));

  // R5: push and pop together keep pointer and count
  a_r5_replace_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_empty && push_i && pop_i && !restore_i) |=> $stable(cnt_q) && $stable(top_q));

  // R3: a lone pop lowers the count by one
  a_r3_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_empty && pop_i && !push_i && !restore_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R8: restore loads pointer and clamped count
  a_r8_restore_load: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> (top_q == $past(restore_top_i)) &&
                  (cnt_q == (($past(restore_cnt_i) > FULL_CNT) ? FULL_CNT : $past(restore_cnt_i))));

  // R9: count never exceeds the depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  generate
    if (OVF == OVF_FREEZE) begin : g_freeze_chk
      // R7: push alone to a full stack is dropped
      a_r7_freeze_full: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_i && !pop_i && !restore_i) |=> $stable(cnt_q) && $stable(top_q));
    end else begin : g_wrap_chk
      // R6: push alone to a full stack keeps it full and advances
      a_r6_wrap_full: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_i && !pop_i && !restore_i) |=>
          (cnt_q == FULL_CNT) && (top_q != $past(top_q)));
    end
  endgenerate

endmodule

// File: rtl/ras_entry_store.sv
module ras_entry_store #(
  parameter int  DEPTH = 4,
  parameter int  AW    = 32,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);

  logic [AW-1:0] slot [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot[g] <= '0;
        end else if (wr_en_i && (wr_idx_i == PW'(g))) begin
          slot[g] <= wr_data_i;
        end
      end
    end
  endgenerate

  // combinational read of the top slot
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == PW'(i)) rd_data_o = slot[i];
    end
  end

  // R2: the addressed slot holds the written data after the edge
  a_r2_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (slot[$past(wr_idx_i)] == $past(wr_data_i)));

endmodule

// File: rtl/ras_top.sv
module ras_top
  import ras_pkg::*;
#(
  parameter int       DEPTH      = 4,
  parameter int       AW         = 32,
  parameter int       INST_BYTES = 4,
  parameter ras_ovf_e OVF        = OVF_WRAP,
  localparam int      PW         = $clog2(DEPTH),
  localparam int      CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] call_pc_i,
  input  logic          restore_i,
  input  logic [PW-1:0] restore_top_i,
  input  logic [CW-1:0] restore_cnt_i,
  output logic [AW-1:0] pred_target_o,
  output logic          pred_valid_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [PW-1:0] ckpt_top_o,
  output logic [CW-1:0] ckpt_cnt_o
);

  logic [PW-1:0] top_w, wr_idx_w;
  logic [CW-1:0] cnt_w;
  logic          wr_en_w, empty_w, full_w;
  logic [AW-1:0] ret_addr;

  // address of the instruction after the call
  assign ret_addr = call_pc_i + AW'(INST_BYTES);

  ras_ptr_ctrl #(
    .DEPTH(DEPTH),
    .OVF  (OVF)
  ) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .restore_i    (restore_i),
    .restore_top_i(restore_top_i),
    .restore_cnt_i(restore_cnt_i),
    .top_o        (top_w),
    .cnt_o        (cnt_w),
    .empty_o      (empty_w),
    .full_o       (full_w),
    .wr_en_o      (wr_en_w),
    .wr_idx_o     (wr_idx_w)
  );

  ras_entry_store #(
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_w),
    .wr_idx_i (wr_idx_w),
    .wr_data_i(ret_addr),
    .rd_idx_i (top_w),
    .rd_data_o(pred_target_o)
  );

  assign pred_valid_o = !empty_w;
  assign empty_o      = empty_w;
  assign full_o       = full_w;
  assign ckpt_top_o   = top_w;
  assign ckpt_cnt_o   = cnt_w;

  // R2: an accepted push shows its return address next cycle
  a_r2_push_target: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !restore_i && (OVF == OVF_WRAP || !full_o || pop_i)) |=>
      pred_valid_o && (pred_target_o == $past(call_pc_i) + AW'(INST_BYTES)));

  // R3: valid and empty are complementary
  a_r3_valid_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid_o != empty_o);

  // R4: target does not move on an empty pop
  a_r4_empty_target: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i && !restore_i) |=> $stable(pred_target_o) && !pred_valid_o);

endmodule

// File: tb/tb_ras_top.sv
module ras_ref #(
  parameter int DEPTH  = 4,
  parameter bit FREEZE = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic        pop,
  input  logic [31:0] pc,
  input  logic        restore,
  input  int          rtop,
  input  int          rcnt,
  output int          e_top,
  output int          e_cnt,
  output logic [31:0] e_tgt
);
  int          top, cnt;
  logic [31:0] mem [DEPTH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top = 0; cnt = 0;
      for (int i = 0; i < DEPTH; i++) mem[i] = 0;
    end else if (restore) begin
      top = rtop;
      cnt = (rcnt > DEPTH) ? DEPTH : rcnt;
    end else if (push && pop && cnt > 0) begin
      mem[top] = pc + 4;
    end else if (push) begin
      if (!(FREEZE && cnt == DEPTH)) begin
        top = (top + 1) % DEPTH;
        mem[top] = pc + 4;
        if (cnt < DEPTH) cnt = cnt + 1;
      end
    end else if (pop && cnt > 0) begin
      top = (top + DEPTH - 1) % DEPTH;
      cnt = cnt - 1;
    end
    e_top = top; e_cnt = cnt; e_tgt = mem[top];
  end
endmodule

module tb_ras_top;
  import ras_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 0, rst_n = 0;
  logic        push = 0, pop = 0, restore = 0;
  logic [31:0] pc = 0;
  logic [1:0]  rtop_w = 0, rtop_f = 0;
  logic [2:0]  rcnt_w = 0, rcnt_f = 0;

  logic [31:0] tgt_w, tgt_f;
  logic        val_w, val_f, emp_w, emp_f, full_w, full_f;
  logic [1:0]  top_w, top_f;
  logic [2:0]  cnt_w, cnt_f;

  int e_top_w, e_cnt_w, e_top_f, e_cnt_f;
  logic [31:0] e_tgt_w, e_tgt_f;

  int checks = 0, fails = 0;
  bit cmp_on = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_top #(.DEPTH(DEPTH), .OVF(OVF_WRAP)) dut (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .call_pc_i(pc),
    .restore_i(restore), .restore_top_i(rtop_w), .restore_cnt_i(rcnt_w),
    .pred_target_o(tgt_w), .pred_valid_o(val_w), .empty_o(emp_w), .full_o(full_w),
    .ckpt_top_o(top_w), .ckpt_cnt_o(cnt_w));

  ras_top #(.DEPTH(DEPTH), .OVF(OVF_FREEZE)) dut_frz (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .call_pc_i(pc),
    .restore_i(restore), .restore_top_i(rtop_f), .restore_cnt_i(rcnt_f),
    .pred_target_o(tgt_f), .pred_valid_o(val_f), .empty_o(emp_f), .full_o(full_f),
    .ckpt_top_o(top_f), .ckpt_cnt_o(cnt_f));

  ras_ref #(.DEPTH(DEPTH), .FREEZE(0)) ref_w (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .pc(pc), .restore(restore),
    .rtop(int'(rtop_w)), .rcnt(int'(rcnt_w)), .e_top(e_top_w), .e_cnt(e_cnt_w), .e_tgt(e_tgt_w));

  ras_ref #(.DEPTH(DEPTH), .FREEZE(1)) ref_f (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .pc(pc), .restore(restore),
    .rtop(int'(rtop_f)), .rcnt(int'(rcnt_f)), .e_top(e_top_f), .e_cnt(e_cnt_f), .e_tgt(e_tgt_f));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the behavioural models
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(int'(cnt_w) == e_cnt_w, "R3 wrap count", cnt_w, e_cnt_w);
      chk(int'(top_w) == e_top_w, "R8 wrap ckpt top", top_w, e_top_w);
      chk(val_w == (e_cnt_w != 0), "R3 wrap valid", val_w, e_cnt_w != 0);
      chk(full_w == (e_cnt_w == DEPTH), "R9 wrap full", full_w, e_cnt_w == DEPTH);
      chk(tgt_w == e_tgt_w, "R2 wrap target", tgt_w, e_tgt_w);
      chk(int'(cnt_f) == e_cnt_f, "R3 frz count", cnt_f, e_cnt_f);
      chk(int'(top_f) == e_top_f, "R8 frz ckpt top", top_f, e_top_f);
      chk(val_f == (e_cnt_f != 0), "R3 frz valid", val_f, e_cnt_f != 0);
      chk(full_f == (e_cnt_f == DEPTH), "R9 frz full", full_f, e_cnt_f == DEPTH);
      chk(tgt_f == e_tgt_f, "R2 frz target", tgt_f, e_tgt_f);
    end
  end

  // drive one cycle of strobes, then sample after the edge
  task automatic op(input bit ps, input bit pp, input logic [31:0] a);
    @(negedge clk);
    push = ps; pop = pp; pc = a;
    @(posedge clk); #1;
    push = 0; pop = 0; restore = 0;
    @(negedge clk);
  endtask

  task automatic rest(input bit ps, input bit pp, input logic [31:0] a);
    @(negedge clk);
    restore = 1; push = ps; pop = pp; pc = a;
    @(posedge clk); #1;
    push = 0; pop = 0; restore = 0;
    @(negedge clk);
  endtask

  initial begin
    logic [1:0] sv_top_w, sv_top_f;
    logic [2:0] sv_cnt_w, sv_cnt_f;
    logic [31:0] hold;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cnt_w == 0 && top_w == 0, "R1 count/top after reset", {cnt_w, top_w}, 0);
    chk(!val_w && emp_w && !full_w, "R1 flags after reset", {val_w, emp_w, full_w}, 3'b010);
    chk(tgt_w == 0, "R1 target after reset", tgt_w, 0);
    cmp_on = 1;

    // R2 / R3 nested calls
    op(1, 0, 32'h1000);
    chk(tgt_w == 32'h1004 && val_w, "R2 first push target", tgt_w, 32'h1004);
    op(1, 0, 32'h2000);
    op(1, 0, 32'h3000);
    chk(tgt_w == 32'h3004 && cnt_w == 3, "R2 third push target", tgt_w, 32'h3004);
    op(0, 1, 0);
    chk(tgt_w == 32'h2004 && cnt_w == 2, "R3 first pop LIFO", tgt_w, 32'h2004);
    op(0, 1, 0);
    chk(tgt_w == 32'h1004 && cnt_w == 1, "R3 second pop LIFO", tgt_w, 32'h1004);

    // R5 replace in place
    op(1, 1, 32'h4000);
    chk(tgt_w == 32'h4004, "R5 replace target", tgt_w, 32'h4004);
    chk(cnt_w == 1 && top_w == 1, "R5 replace count/top", {cnt_w, top_w}, {3'd1, 2'd1});

    // R4 pop on empty
    op(0, 1, 0);
    chk(!val_w && emp_w, "R3 emptied", val_w, 0);
    hold = tgt_w;
    op(0, 1, 0);
    chk(cnt_w == 0 && top_w == 0, "R4 empty pop count/top", {cnt_w, top_w}, 0);
    chk(tgt_w == hold && !val_w, "R4 empty pop target", tgt_w, hold);

    // R5 push+pop on empty acts as push
    op(1, 1, 32'h5000);
    chk(cnt_w == 1 && tgt_w == 32'h5004, "R5 push+pop on empty", tgt_w, 32'h5004);
    op(0, 1, 0);

    // R9 / R6 / R7 overflow
    op(1, 0, 32'hA000);
    op(1, 0, 32'hB000);
    op(1, 0, 32'hC000);
    op(1, 0, 32'hD000);
    chk(full_w && full_f && cnt_w == 4, "R9 full at depth", {full_w, full_f}, 2'b11);
    op(1, 0, 32'hE000);
    chk(tgt_w == 32'hE004 && cnt_w == 4, "R6 wrap overwrite target", tgt_w, 32'hE004);
    chk(tgt_f == 32'hD004 && cnt_f == 4, "R7 freeze ignores push", tgt_f, 32'hD004);
    op(0, 1, 0);
    chk(tgt_w == 32'hD004, "R6 wrap pop 1", tgt_w, 32'hD004);
    chk(tgt_f == 32'hC004, "R7 freeze pop 1 stale", tgt_f, 32'hC004);
    op(0, 1, 0);
    op(0, 1, 0);
    chk(tgt_w == 32'hB004 && cnt_w == 1, "R6 wrap pop 3", tgt_w, 32'hB004);
    chk(tgt_f == 32'hA004 && cnt_f == 1, "R7 freeze pop 3", tgt_f, 32'hA004);
    op(0, 1, 0);
    chk(!val_w && !val_f, "R6 oldest lost after depth pops", {val_w, val_f}, 0);

    // R8 checkpoint and restore
    op(1, 0, 32'h6000);
    op(1, 0, 32'h7000);
    sv_top_w = top_w; sv_cnt_w = cnt_w; sv_top_f = top_f; sv_cnt_f = cnt_f;
    chk(sv_cnt_w == 2, "R8 ckpt count", sv_cnt_w, 2);
    op(0, 1, 0);
    op(0, 1, 0);
    op(1, 0, 32'h8000);
    rtop_w = sv_top_w; rcnt_w = sv_cnt_w; rtop_f = sv_top_f; rcnt_f = sv_cnt_f;
    rest(0, 0, 0);
    chk(top_w == sv_top_w && cnt_w == sv_cnt_w, "R8 restore loads ckpt", {cnt_w, top_w}, {sv_cnt_w, sv_top_w});
    chk(tgt_w == 32'h7004 && tgt_f == 32'h7004, "R8 restored target", tgt_w, 32'h7004);
    op(0, 1, 0);
    chk(tgt_w == 32'h8004, "R8 overwritten slot visible", tgt_w, 32'h8004);
    rest(1, 1, 32'h9000);
    chk(cnt_w == sv_cnt_w && tgt_w == 32'h7004, "R8 restore beats push/pop", tgt_w, 32'h7004);
    rcnt_w = 3'd7; rcnt_f = 3'd7;
    rest(0, 0, 0);
    chk(cnt_w == 4 && full_w, "R8 restore count clamp", cnt_w, 4);

    // random phase, compared every cycle against the models
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 19));
      @(negedge clk);
      if (r == 0) begin
        sv_top_w = top_w; sv_cnt_w = cnt_w; sv_top_f = top_f; sv_cnt_f = cnt_f;
      end
      push = (r >= 1 && r <= 8) || r == 17;
      pop  = (r >= 9 && r <= 16) || r == 17;
      restore = (r == 18);
      rtop_w = sv_top_w; rcnt_w = sv_cnt_w; rtop_f = sv_top_f; rcnt_f = sv_cnt_f;
      pc = $urandom & 32'hFFFF_FFFC;
      @(posedge clk); #1;
      push = 0; pop = 0; restore = 0;
    end
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule